// File: doc/BRIEF.md
# Two-Stage Fractional Baud Strobe Generator

This block turns a fast reference clock into the timing strobes that a UART transmitter and receiver need, and it supports divide ratios that are not whole numbers. It does not shift any data. It only marks when a sample should be taken and when a bit period is over. It has two modes. In low-frequency mode, a bit lasts an integer prescale count of reference cycles, plus one extra cycle on the bit positions that a per-bit pattern selects. In oversampling mode, a bit is split into 16 sub-periods. A first-stage fraction stretches some of those sub-periods by one cycle each. The same per-bit pattern can then append one more cycle after the 16th sub-period.

The surrounding UART pulses `restart` when a frame begins. On receive, that pulse comes at the detected start edge. The block raises `sample_tick` at the end of each sub-period and `bit_tick` when a bit period has fully elapsed. Software or a configuration block computes the prescale, fraction and pattern values for a given ratio N. The prescale is INT(N/16) and the fraction is the 4-bit value INT(frac(N/16)*16). The start edge is not aligned to the reference clock, so the receive path inherits an uncertainty of up to half a reference cycle either way, whichever mode is selected.

Top module: `baud_frac_gen`

## Requirements
- R1: When `restart` is high, both ticks are low. At the next edge all counters clear and the bit index returns to 0. The first cycle after `restart` falls is cycle 1 of bit 0. Reset behaves the same way.
- R2: With `os_mode`=0, bit i lasts P + `bit_pattern[i]` reference cycles, where P is the effective prescale. `bit_tick` is high for one cycle, during the last cycle of the bit.
- R3: With `os_mode`=0, `sample_tick` stays low.
- R4: With `os_mode`=1, sub-period j (j = 0..15) of every bit lasts P + m1[j] cycles. `sample_tick` is high during the last cycle of each sub-period.
- R5: m1[j] = floor((j+1)*F/16) - floor(j*F/16), where F is `frac_sel`. The pattern therefore holds exactly F ones, spread evenly across the 16 sub-periods.
- R6: With `os_mode`=1 and `bit_pattern[i]`=0, `bit_tick` coincides with the 16th `sample_tick`. With `bit_pattern[i]`=1, one extra cycle follows the 16th sub-period, and `bit_tick` is raised in that cycle.
- R7: Frame bit i uses pattern bit i mod 8, with bit 0 of `bit_pattern` applying to the first bit after restart. After the 8th bit, the index wraps to 0.
- R8: A `prescale` of 0 acts as 1 in both modes.
- R9: While `enable` is low, no tick is raised and all counting is frozen. When `enable` rises again, counting resumes where it stopped.
- R10: In oversampling mode, exactly 16 `sample_tick` pulses occur per bit, with the last of them no later than the `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Count enable; low freezes the generator |
| restart | input | 1 | Start-of-frame restart; clears counters and bit index |
| os_mode | input | 1 | 0 = low-frequency mode, 1 = oversampling mode |
| prescale | input | PRESCALE_W (16) | Integer prescale count (0 treated as 1) |
| frac_sel | input | 4 | First-stage fraction: number of stretched sub-periods per bit |
| bit_pattern | input | 8 | Second-stage per-bit extra-cycle pattern, bit 0 = first bit |
| sample_tick | output | 1 | One-cycle strobe at the end of each sub-period (oversampling only) |
| bit_tick | output | 1 | One-cycle strobe at the end of each bit period |

## Verification
Both ticks are decoded combinationally from registered counter state. A tick is therefore high during the cycle that completes its segment, counting from the first cycle after `restart` falls as cycle 1. The bench builds, from the formulas above, the list of cycle numbers at which each tick is due. It then compares both outputs in every cycle at the falling edge, after the edge that moved the counters has settled. Cycles with `enable` low are not counted in the timeline, and in them both ticks are expected low. Each scenario also checks the totals of sample and bit ticks against 16 per bit and one per bit.

// File: rtl/baud_frac_pkg.sv
`timescale 1ns/1ps
package baud_frac_pkg;

  typedef enum logic {
    MODE_LOWFREQ   = 1'b0,
    MODE_OVERSAMPLE = 1'b1
  } baud_mode_e;

  // Number of stretch cycles owed to slot j when f of n slots are stretched:
  // evenly spread, exactly f ones across n slots.
  function automatic int unsigned slot_stretch(input int unsigned f,
                                               input int unsigned j,
                                               input int unsigned n);
    return ((j + 1) * f) / n - (j * f) / n;
  endfunction

  // Prescale floor: zero would stall the counter, so it acts as one.
  function automatic int unsigned clamp_prescale(input int unsigned p);
    return (p == 0) ? 1 : p;
  endfunction

endpackage

// File: rtl/baud_frac_pattern.sv
`timescale 1ns/1ps
module baud_frac_pattern #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic [SLOT_W-1:0] frac_sel,
  output logic [SLOTS-1:0]  stretch_map
);
  import baud_frac_pkg::*;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    assign stretch_map[j] =
      (slot_stretch(32'(frac_sel), 32'(j), 32'(SLOTS)) != 32'd0);
  end

endmodule

// File: rtl/baud_seg_counter.sv
`timescale 1ns/1ps
module baud_seg_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] seg_len,
  output logic             seg_last,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  assign seg_last = run && (cnt_q == seg_len - 1'b1);
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (run) begin
      if (seg_last) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/baud_bit_sequencer.sv
`timescale 1ns/1ps
module baud_bit_sequencer #(
  parameter int SLOTS  = 16,
  parameter int SLOT_W = $clog2(SLOTS),
  parameter int PAT_W  = 8,
  parameter int BIDX_W = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              os_mode,
  input  logic              seg_last,
  input  logic              extra_due,
  output logic [SLOT_W-1:0] slot,
  output logic [BIDX_W-1:0] bit_idx,
  output logic              in_extra,
  output logic              sample_evt,
  output logic              bit_evt
);
  import baud_frac_pkg::*;

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [BIDX_W-1:0] LAST_BIT  = BIDX_W'(PAT_W - 1);

  baud_mode_e         mode;
  logic [SLOT_W-1:0]  slot_q;
  logic [BIDX_W-1:0]  bit_q;
  logic               extra_q;
  logic               slot_last;
  logic               enter_extra;

  assign mode      = baud_mode_e'(os_mode);
  assign slot_last = (slot_q == LAST_SLOT);

  always_comb begin
    sample_evt  = 1'b0;
    bit_evt     = 1'b0;
    enter_extra = 1'b0;
    if (mode == MODE_LOWFREQ) begin
      bit_evt = seg_last;
    end else if (extra_q) begin
      bit_evt = seg_last;
    end else begin
      sample_evt  = seg_last;
      bit_evt     = seg_last && slot_last && !extra_due;
      enter_extra = seg_last && slot_last && extra_due;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      slot_q  <= '0;
      bit_q   <= '0;
      extra_q <= 1'b0;
    end else if (bit_evt) begin
      slot_q  <= '0;
      extra_q <= 1'b0;
      bit_q   <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
    end else if (enter_extra) begin
      extra_q <= 1'b1;
    end else if (sample_evt) begin
      slot_q  <= slot_q + 1'b1;
    end
  end

  assign slot     = slot_q;
  assign bit_idx  = bit_q;
  assign in_extra = extra_q;

endmodule

// File: rtl/baud_frac_gen.sv
`timescale 1ns/1ps
module baud_frac_gen #(
  parameter int PRESCALE_W = 16,
  parameter int SLOTS      = 16,
  parameter int PAT_W      = 8,
  parameter int SLOT_W     = $clog2(SLOTS),
  parameter int BIDX_W     = (PAT_W > 1) ? $clog2(PAT_W) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable,
  input  logic                  restart,
  input  logic                  os_mode,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic [SLOT_W-1:0]     frac_sel,
  input  logic [PAT_W-1:0]      bit_pattern,
  output logic                  sample_tick,
  output logic                  bit_tick
);
  import baud_frac_pkg::*;

  localparam int CNT_W = PRESCALE_W + 1;

  // Named internal events, brought out for the bound checker.
  logic                  run;
  logic [PRESCALE_W-1:0] p_eff;
  logic [SLOTS-1:0]      stretch_map;
  logic [SLOT_W-1:0]     slot_idx;
  logic [BIDX_W-1:0]     bit_idx;
  logic                  in_extra;
  logic                  cur_extra;
  logic                  cur_stretch;
  logic [CNT_W-1:0]      seg_len;
  logic [CNT_W-1:0]      seg_count;
  logic                  seg_last;
  logic                  sample_evt;
  logic                  bit_evt;

  assign run         = enable && !restart;
  assign p_eff       = PRESCALE_W'(clamp_prescale(32'(prescale)));
  assign cur_extra   = bit_pattern[bit_idx];
  assign cur_stretch = stretch_map[slot_idx];

  always_comb begin
    if (baud_mode_e'(os_mode) == MODE_LOWFREQ)
      seg_len = {1'b0, p_eff} + CNT_W'(cur_extra);
    else if (in_extra)
      seg_len = CNT_W'(1);
    else
      seg_len = {1'b0, p_eff} + CNT_W'(cur_stretch);
  end

  baud_frac_pattern #(
    .SLOTS (SLOTS),
    .SLOT_W(SLOT_W)
  ) pattern_i (
    .frac_sel   (frac_sel),
    .stretch_map(stretch_map)
  );

  baud_seg_counter #(
    .CNT_W(CNT_W)
  ) counter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (run),
    .seg_len (seg_len),
    .seg_last(seg_last),
    .count   (seg_count)
  );

  baud_bit_sequencer #(
    .SLOTS (SLOTS),
    .SLOT_W(SLOT_W),
    .PAT_W (PAT_W),
    .BIDX_W(BIDX_W)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .os_mode   (os_mode),
    .seg_last  (seg_last),
    .extra_due (cur_extra),
    .slot      (slot_idx),
    .bit_idx   (bit_idx),
    .in_extra  (in_extra),
    .sample_evt(sample_evt),
    .bit_evt   (bit_evt)
  );

  assign sample_tick = sample_evt;
  assign bit_tick    = bit_evt;

endmodule

// File: rtl/baud_frac_gen_checks.sv
`timescale 1ns/1ps
module baud_frac_gen_checks #(
  parameter int PRESCALE_W = 16,
  parameter int SLOTS      = 16,
  parameter int PAT_W      = 8,
  parameter int SLOT_W     = $clog2(SLOTS),
  parameter int BIDX_W     = (PAT_W > 1) ? $clog2(PAT_W) : 1,
  parameter int CNT_W      = PRESCALE_W + 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  enable,
  input logic                  restart,
  input logic                  os_mode,
  input logic [PRESCALE_W-1:0] prescale,
  input logic                  sample_tick,
  input logic                  bit_tick,
  input logic [SLOT_W-1:0]     slot_idx,
  input logic [BIDX_W-1:0]     bit_idx,
  input logic                  in_extra,
  input logic [CNT_W-1:0]      seg_len,
  input logic [CNT_W-1:0]      seg_count
);
  logic       armed_q;
  logic       mode_q;
  logic [7:0] samples_q;

  // Sample ticks seen in the current bit; valid once a restart armed it.
  always_ff @(posedge clk) begin
    mode_q <= os_mode;
    if (!rst_n) begin
      armed_q   <= 1'b0;
      samples_q <= '0;
    end else if (restart) begin
      armed_q   <= 1'b1;
      samples_q <= '0;
    end else begin
      if (os_mode != mode_q) armed_q <= 1'b0;
      if (bit_tick)          samples_q <= '0;
      else if (sample_tick)  samples_q <= samples_q + 8'd1;
    end
  end

  assert_quiet_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (!sample_tick && !bit_tick));

  assert_clean_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (bit_idx == '0 && slot_idx == '0 && !in_extra && seg_count == '0));

  assert_seg_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> (seg_count < seg_len));

  assert_lf_no_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !os_mode |-> !sample_tick);

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (os_mode && prescale > 1 && sample_tick) |=> !sample_tick);

  assert_extra_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (os_mode && $past(os_mode) && $past(enable) && !$past(restart)
     && bit_tick && !sample_tick) |-> $past(sample_tick));

  assert_index_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && bit_idx == BIDX_W'(PAT_W - 1)) |=> (bit_idx == '0));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart) |=> (seg_count == $past(seg_count)
                               && slot_idx == $past(slot_idx)));

  assert_sixteen_samples_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && os_mode && mode_q && bit_tick)
      |-> ((samples_q + 8'(sample_tick)) == 8'(SLOTS)));

endmodule

bind baud_frac_gen baud_frac_gen_checks #(
  .PRESCALE_W(PRESCALE_W),
  .SLOTS     (SLOTS),
  .PAT_W     (PAT_W),
  .SLOT_W    (SLOT_W),
  .BIDX_W    (BIDX_W)
) checks_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .restart    (restart),
  .os_mode    (os_mode),
  .prescale   (prescale),
  .sample_tick(sample_tick),
  .bit_tick   (bit_tick),
  .slot_idx   (slot_idx),
  .bit_idx    (bit_idx),
  .in_extra   (in_extra),
  .seg_len    (seg_len),
  .seg_count  (seg_count)
);

// File: tb/baud_frac_gen_tb_top.sv
`timescale 1ns/1ps
module baud_frac_gen_tb_top;

  localparam int MAXC = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        restart = 1'b0;
  logic        os_mode = 1'b0;
  logic [15:0] prescale = 16'd4;
  logic [3:0]  frac_sel = 4'd0;
  logic [7:0]  bit_pattern = 8'd0;
  logic        sample_tick;
  logic        bit_tick;

  int n_checks = 0;
  int n_fail   = 0;

  logic exp_s [MAXC];
  logic exp_b [MAXC];

  always #10 clk = ~clk;

  baud_frac_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .restart    (restart),
    .os_mode    (os_mode),
    .prescale   (prescale),
    .frac_sel   (frac_sel),
    .bit_pattern(bit_pattern),
    .sample_tick(sample_tick),
    .bit_tick   (bit_tick)
  );

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  // Expected tick timeline, cycle 1 = first cycle after restart falls.
  // Stretch bits come from a running accumulator rather than a division.
  task automatic build_expect(input bit os, input int p, input int f,
                              input logic [7:0] pat, input int nbits,
                              output int total);
    int t   = 0;
    int acc = 0;
    int pe  = (p == 0) ? 1 : p;
    for (int c = 0; c < MAXC; c++) begin
      exp_s[c] = 1'b0;
      exp_b[c] = 1'b0;
    end
    for (int i = 0; i < nbits; i++) begin
      if (!os) begin
        t += pe + int'(pat[i % 8]);
      end else begin
        acc = 0;
        for (int j = 0; j < 16; j++) begin
          int stretch = 0;
          acc += f;
          if (acc >= 16) begin
            acc -= 16;
            stretch = 1;
          end
          t += pe + stretch;
          exp_s[t] = 1'b1;
        end
        t += int'(pat[i % 8]);
      end
      exp_b[t] = 1'b1;
    end
    total = t;
  endtask

  task automatic run_scenario(input string req, input bit os, input int p,
                              input int f, input logic [7:0] pat,
                              input int nbits, input int freeze_at,
                              input int freeze_len);
    int total;
    int act = 0;
    int cyc = 0;
    int mism = 0;
    int first_bad = -1;
    int bad_act = 0;
    int bad_exp = 0;
    int seen_s = 0;
    int seen_b = 0;
    int froze_bad = 0;
    build_expect(os, p, f, pat, nbits, total);
    @(posedge clk); #1;
    restart     = 1'b1;
    enable      = 1'b1;
    os_mode     = os;
    prescale    = 16'(p);
    frac_sel    = 4'(f);
    bit_pattern = pat;
    @(negedge clk);
    check("R1", {req, " ticks low during restart"},
          int'({sample_tick, bit_tick}), 0);
    while (act < total) begin
      @(posedge clk); #1;
      restart = 1'b0;
      enable  = !(cyc >= freeze_at && cyc < freeze_at + freeze_len);
      @(negedge clk);
      cyc++;
      if (enable) begin
        act++;
        seen_s += int'(sample_tick);
        seen_b += int'(bit_tick);
        if (sample_tick !== exp_s[act] || bit_tick !== exp_b[act]) begin
          mism++;
          if (first_bad < 0) begin
            first_bad = act;
            bad_act   = int'({sample_tick, bit_tick});
            bad_exp   = int'({exp_s[act], exp_b[act]});
          end
        end
      end else if (sample_tick || bit_tick) begin
        froze_bad++;
      end
    end
    check(req, $sformatf("tick timeline {sample,bit} first mismatch at cycle %0d",
                         first_bad), bad_act, bad_exp);
    check(req, "bit tick count", seen_b, nbits);
    check(req, "sample tick count (R10 / R3)", seen_s, os ? 16 * nbits : 0);
    if (freeze_len > 0)
      check("R9", "ticks while enable low", froze_bad, 0);
    if (mism != 0)
      $display("  %s: %0d mismatching cycles", req, mism);
  endtask

  task automatic test_reset;
    @(negedge clk);
    check("R1", "sample_tick in reset", int'(sample_tick), 0);
    check("R1", "bit_tick in reset", int'(bit_tick), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    test_reset();
    // R2 R3 R7: low-frequency, prescale 5, pattern wraps over 10 bits
    run_scenario("R2 R7", 1'b0, 5, 0, 8'b1010_0110, 10, 0, 0);
    // R8: prescale 0 acts as 1 in low-frequency mode
    run_scenario("R8 lowfreq", 1'b0, 0, 0, 8'h0F, 9, 0, 0);
    // R4 R5 R6: oversampling, fraction 5, extra cycle on bits 0 and 7
    run_scenario("R4 R5 R6", 1'b1, 2, 5, 8'h81, 9, 0, 0);
    // R5 boundary: fraction 15, every bit extended
    run_scenario("R5 frac15", 1'b1, 3, 15, 8'hFF, 3, 0, 0);
    // R4 boundary: one-cycle sub-periods, no fraction
    run_scenario("R4 unit", 1'b1, 1, 0, 8'h00, 4, 0, 0);
    // R8: prescale 0 in oversampling mode
    run_scenario("R8 oversample", 1'b1, 0, 3, 8'hAA, 4, 0, 0);
    // R9: freeze in the middle of a bit, then resume
    run_scenario("R9 freeze", 1'b1, 3, 8, 8'h55, 9, 37, 11);
    // R6 R9: freeze spanning the extra cycle region of bit 0
    run_scenario("R6 freeze", 1'b1, 2, 0, 8'h01, 2, 31, 4);
    // R1: restart mid-frame from the previous run, lowfreq again
    run_scenario("R1 restart", 1'b0, 3, 0, 8'h02, 3, 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule